// File: doc/BRIEF.md
# Byte-Bus Multicycle Microcoded Controller

This block is the control unit and datapath of a small accumulator-style processor whose only path to memory is one byte wide. Every instruction is 16 bits. It is brought in over two memory reads, lower address first, through an 8-bit memory data register. It then runs a fixed microstep sequence for the instruction found in the instruction register. Two instructions are supported:

- a pre-decrement indirect byte store, which lowers the X pointer (register pair 27:26), writes it back, and stores register 14 at the new address;
- an indirect subroutine call, which pushes the return address onto a downward-growing stack and jumps to the address held in the Z pair (31:30).

The register file has a single port, so one register is read or written per cycle. Only PC, SP and AC can count up or down by themselves. Pointer arithmetic on X therefore goes through AC, and each 16-bit pointer is gathered in two cycles. Memory is synchronous: read data arrives one cycle after the address, and a write takes effect at the clock edge that ends the cycle in which the write enable is high. Debug outputs show PC, SP and the current microstep. The register-file reset contents are set by parameters.

Top module: `mcpu_ctrl`

## Requirements
- R1: While reset is high and after it, until the first operating edge, dbg_pc equals PC_RESET, dbg_sp equals SP_RESET, dbg_step is 0 and mem_we is 0.
- R2: Fetch takes exactly 6 cycles. It reads the instruction byte at PC into IR bits 7:0 and the byte at PC+1 into IR bits 15:8, and leaves PC advanced by 2. dbg_step shows fetch step n as n (0 to 5) and execute step n as 8+n.
- R3: Opcode 0x92EE (pre-decrement store of register 14 through X) uses 7 execute cycles. mem_we is high only in execute step 6, with mem_addr equal to X-1 and mem_wdata equal to register 14. The instruction takes 13 cycles in total.
- R4: The store writes both bytes of the decremented X back to registers 26 and 27. Successive stores therefore walk down one byte each, and the borrow carries into the high byte (0x0100 is followed by 0x00FF). No other register is written, so register 14 is unchanged.
- R5: Opcode 0x9509 (indirect call) uses 6 execute cycles. The return address is the PC after fetch. Its low byte is written at SP in execute step 1, and SP then drops by 1. Its high byte is written at the new SP in execute step 3, and SP then drops by 1 again, ending at SP-2. SP never changes by any other amount.
- R6: At the end of the call, PC holds Z ({register 31, register 30}), and the next fetch starts from that address.
- R7: Any other opcode spends one execute cycle and returns to fetch step 0. It causes no memory write and changes neither SP nor PC beyond the fetch increment.
- R8: mem_we is high only during execute steps, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Byte address (the address register) |
| mem_wdata | output | DATA_W | Write data (the memory data register) |
| mem_we | output | 1 | Write enable; the write takes effect at the edge that ends the cycle |
| mem_rdata | input | DATA_W | Read data for the address of the previous cycle |
| dbg_pc | output | ADDR_W | Program counter |
| dbg_sp | output | ADDR_W | Stack pointer |
| dbg_step | output | 4 | {execute flag, microstep} |

## Verification
During the call, three things happen in the same cycle: the write of the low return byte, the decrement of SP, and the reload of the data register with the high byte. A late register or a swapped order would therefore put the wrong byte at the wrong address. The bench runs a call and samples mem_we, mem_addr and mem_wdata in execute step 1. It then checks that SP has dropped by one in the next step, and that the final stack bytes hold the low byte at the higher address. The store has the same kind of overlap: in execute step 3 the decremented AC goes both to the register port and to the address register. The bench runs four stores in a row, crossing a page boundary, and compares the addresses they hit against the expected walk.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  localparam int unsigned STEP_W = 3;

  localparam logic [15:0] OP_STORE_PREDEC = 16'h92EE;
  localparam logic [15:0] OP_CALL_Z       = 16'h9509;

  localparam int unsigned REG_SRC = 14;
  localparam int unsigned REG_XL  = 26;
  localparam int unsigned REG_XH  = 27;
  localparam int unsigned REG_ZL  = 30;
  localparam int unsigned REG_ZH  = 31;

  localparam int unsigned FETCH_LAST = 5;
  localparam int unsigned STORE_LAST = 6;
  localparam int unsigned CALL_LAST  = 5;
  localparam int unsigned NONE_LAST  = 0;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_STORE = 2'd1,
    K_CALL  = 2'd2
  } op_kind_t;

endpackage

// File: rtl/mcpu_seq.sv
module mcpu_seq
  import mcpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       ir,
  output logic              in_exec,
  output logic [STEP_W-1:0] step,
  output op_kind_t          kind
);

  localparam logic [STEP_W-1:0] F_LAST = STEP_W'(FETCH_LAST);
  localparam logic [STEP_W-1:0] S_LAST = STEP_W'(STORE_LAST);
  localparam logic [STEP_W-1:0] C_LAST = STEP_W'(CALL_LAST);
  localparam logic [STEP_W-1:0] N_LAST = STEP_W'(NONE_LAST);

  logic [STEP_W-1:0] exec_last;

  // Decode the held instruction word
  always_comb begin
    if (ir == OP_STORE_PREDEC)  kind = K_STORE;
    else if (ir == OP_CALL_Z)   kind = K_CALL;
    else                        kind = K_NONE;
  end

  always_comb begin
    case (kind)
      K_STORE: exec_last = S_LAST;
      K_CALL:  exec_last = C_LAST;
      default: exec_last = N_LAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_exec <= 1'b0;
      step    <= '0;
    end else if (!in_exec) begin
      if (step == F_LAST) begin
        in_exec <= 1'b1;
        step    <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end else begin
      if (step == exec_last) begin
        in_exec <= 1'b0;
        step    <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  AST_BAD_OP_RETURN: assert property (@(posedge clk) disable iff (rst)
    (in_exec && step == '0 && kind == K_NONE) |=> (!in_exec && step == '0)); // R7

endmodule

// File: rtl/mcpu_rf.sv
module mcpu_rf #(
  parameter int unsigned     NREG     = 32,
  parameter int unsigned     DATA_W   = 8,
  parameter int unsigned     REG_AW   = $clog2(NREG),
  parameter logic [2*DATA_W-1:0] X_INIT   = '0,
  parameter logic [2*DATA_W-1:0] Z_INIT   = '0,
  parameter logic [DATA_W-1:0]   SRC_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [NREG];

  function automatic logic [DATA_W-1:0] init_val(input int unsigned idx);
    if (idx == mcpu_pkg::REG_XL)       return X_INIT[DATA_W-1:0];
    else if (idx == mcpu_pkg::REG_XH)  return X_INIT[2*DATA_W-1:DATA_W];
    else if (idx == mcpu_pkg::REG_ZL)  return Z_INIT[DATA_W-1:0];
    else if (idx == mcpu_pkg::REG_ZH)  return Z_INIT[2*DATA_W-1:DATA_W];
    else if (idx == mcpu_pkg::REG_SRC) return SRC_INIT;
    else                               return '0;
  endfunction

  // One port: a single address serves the read and the write
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= init_val(i);
    end else if (we) begin
      regs[addr] <= wdata;
    end
  end

  assign rdata = regs[addr];

  AST_RF_XONLY: assert property (@(posedge clk) disable iff (rst)
    we |-> (addr == REG_AW'(mcpu_pkg::REG_XL) || addr == REG_AW'(mcpu_pkg::REG_XH))); // R4

endmodule

// File: rtl/mcpu_dp.sv
module mcpu_dp
  import mcpu_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       REG_AW   = 5,
  parameter logic [ADDR_W-1:0] PC_RESET = '0,
  parameter logic [ADDR_W-1:0] SP_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_exec,
  input  logic [STEP_W-1:0] step,
  input  op_kind_t          kind,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [15:0]       ir,
  output logic [REG_AW-1:0] rf_addr,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata
);

  localparam int unsigned HI = ADDR_W - 1;
  localparam int unsigned LO = DATA_W;

  logic [ADDR_W-1:0] ac;

  // Register-file port control: one access per step
  always_comb begin
    rf_addr  = '0;
    rf_we    = 1'b0;
    rf_wdata = ac[DATA_W-1:0];
    if (in_exec) begin
      if (kind == K_STORE) begin
        case (step)
          3'd0: rf_addr = REG_AW'(REG_XL);
          3'd1: rf_addr = REG_AW'(REG_XH);
          3'd3: begin rf_addr = REG_AW'(REG_XL); rf_we = 1'b1; rf_wdata = ac[DATA_W-1:0]; end
          3'd4: begin rf_addr = REG_AW'(REG_XH); rf_we = 1'b1; rf_wdata = ac[HI:LO]; end
          3'd5: rf_addr = REG_AW'(REG_SRC);
          default: ;
        endcase
      end else if (kind == K_CALL) begin
        case (step)
          3'd4: rf_addr = REG_AW'(REG_ZL);
          3'd5: rf_addr = REG_AW'(REG_ZH);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= PC_RESET;
      sp     <= SP_RESET;
      ac     <= '0;
      mar    <= '0;
      mdr    <= '0;
      ir     <= '0;
      mem_we <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (!in_exec) begin
        case (step)
          3'd0: mar <= pc;
          3'd1: pc  <= pc + ADDR_W'(1);
          3'd2: begin mdr <= mem_rdata; mar <= pc; end
          3'd3: begin ir[7:0] <= mdr; pc <= pc + ADDR_W'(1); end
          3'd4: mdr <= mem_rdata;
          3'd5: ir[15:8] <= mdr;
          default: ;
        endcase
      end else if (kind == K_STORE) begin
        case (step)
          3'd0: ac[DATA_W-1:0] <= rf_rdata;
          3'd1: ac[HI:LO]      <= rf_rdata;
          3'd2: ac             <= ac - ADDR_W'(1);
          3'd3: mar            <= ac;
          3'd5: begin mdr <= rf_rdata; mem_we <= 1'b1; end
          default: ;
        endcase
      end else if (kind == K_CALL) begin
        case (step)
          3'd0: begin mar <= sp; mdr <= pc[DATA_W-1:0]; mem_we <= 1'b1; end
          3'd1: begin sp <= sp - ADDR_W'(1); mdr <= pc[HI:LO]; end
          3'd2: begin mar <= sp; mem_we <= 1'b1; end
          3'd3: sp <= sp - ADDR_W'(1);
          3'd4: pc[DATA_W-1:0] <= rf_rdata;
          3'd5: pc[HI:LO]      <= rf_rdata;
          default: ;
        endcase
      end
    end
  end

  AST_WE_EXEC_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> in_exec); // R8

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R8

  AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    (sp != $past(sp)) |-> (sp == $past(sp) - ADDR_W'(1))); // R5

endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
  import mcpu_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 16,
  parameter int unsigned         DATA_W   = 8,
  parameter int unsigned         NREG     = 32,
  parameter logic [ADDR_W-1:0]   PC_RESET = 16'h0120,
  parameter logic [ADDR_W-1:0]   SP_RESET = 16'h03F0,
  parameter logic [2*DATA_W-1:0] X_INIT   = 16'h0102,
  parameter logic [2*DATA_W-1:0] Z_INIT   = 16'h0040,
  parameter logic [DATA_W-1:0]   SRC_INIT = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [ADDR_W-1:0] dbg_sp,
  output logic [STEP_W:0]   dbg_step
);

  localparam int unsigned REG_AW = $clog2(NREG);

  logic              in_exec;
  logic [STEP_W-1:0] step;
  op_kind_t          kind;
  logic [15:0]       ir;
  logic [REG_AW-1:0] rf_addr;
  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata;
  logic [DATA_W-1:0] rf_rdata;

  mcpu_seq seq_i (
    .clk     (clk),
    .rst     (rst),
    .ir      (ir),
    .in_exec (in_exec),
    .step    (step),
    .kind    (kind)
  );

  mcpu_rf #(
    .NREG     (NREG),
    .DATA_W   (DATA_W),
    .REG_AW   (REG_AW),
    .X_INIT   (X_INIT),
    .Z_INIT   (Z_INIT),
    .SRC_INIT (SRC_INIT)
  ) rf_i (
    .clk   (clk),
    .rst   (rst),
    .addr  (rf_addr),
    .we    (rf_we),
    .wdata (rf_wdata),
    .rdata (rf_rdata)
  );

  mcpu_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_AW   (REG_AW),
    .PC_RESET (PC_RESET),
    .SP_RESET (SP_RESET)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .in_exec   (in_exec),
    .step      (step),
    .kind      (kind),
    .mem_rdata (mem_rdata),
    .rf_rdata  (rf_rdata),
    .mar       (mem_addr),
    .mdr       (mem_wdata),
    .mem_we    (mem_we),
    .pc        (dbg_pc),
    .sp        (dbg_sp),
    .ir        (ir),
    .rf_addr   (rf_addr),
    .rf_we     (rf_we),
    .rf_wdata  (rf_wdata)
  );

  assign dbg_step = {in_exec, step};

endmodule

// File: tb/mcpu_ctrl_tb_top.sv
module mcpu_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SP0 = 16'h03F0;
  localparam logic [7:0]  SRC = 8'hA5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic [15:0] dbg_pc;
  logic [15:0] dbg_sp;
  logic [3:0]  dbg_step;

  int tests = 0;
  int fails = 0;
  int wr_cnt = 0;
  bit done = 1'b0;

  logic [7:0] mem [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcpu_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .dbg_pc    (dbg_pc),
    .dbg_sp    (dbg_sp),
    .dbg_step  (dbg_step)
  );

  function automatic logic [7:0] init_byte(input int a);
    if (a >= 16'h0120 && a <= 16'h0127) return (a[0] == 1'b0) ? 8'hEE : 8'h92;
    else if (a == 16'h012A) return 8'h09;
    else if (a == 16'h012B) return 8'h95;
    else if (a == 16'h0040) return 8'hEE;
    else if (a == 16'h0041) return 8'h92;
    else if (a >= 16'h00F0 && a <= 16'h0103) return 8'h11;
    else return 8'h00;
  endfunction

  // Synchronous byte memory: registered read, write at the edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_byte(i);
      mem_rdata <= 8'h00;
      wr_cnt    <= 0;
    end else begin
      if (mem_we) begin
        mem[mem_addr[9:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 pc", dbg_pc, 32'h0120);
    check("R1 sp", dbg_sp, SP0);
    check("R1 step", dbg_step, 0);
    check("R1 we", mem_we, 0);
  endtask

  task automatic t_store_first;
    run(6);
    check("R2 step after fetch", dbg_step, 8);
    check("R2 pc after fetch", dbg_pc, 32'h0122);
    run(6);
    check("R3 we in step 6", mem_we, 1);
    check("R3 addr", mem_addr, 32'h0101);
    check("R3 data", mem_wdata, SRC);
    run(1);
    check("R3 memory", mem[16'h0101], SRC);
    check("R3 back to fetch", dbg_step, 0);
  endtask

  task automatic t_store_walk;
    run(13);
    check("R4 second store", mem[16'h0100], SRC);
    run(13);
    check("R4 borrow store", mem[16'h00FF], SRC);
    run(13);
    check("R4 high byte kept", mem[16'h00FE], SRC);
    check("R4 untouched byte", mem[16'h0102], 8'h11);
    check("R4 write count", wr_cnt, 4);
  endtask

  task automatic t_bad_op;
    run(6);
    check("R7 enters exec", dbg_step, 8);
    run(1);
    check("R7 returns", dbg_step, 0);
    check("R7 pc", dbg_pc, 32'h012A);
    check("R7 sp", dbg_sp, SP0);
    check("R7 no write", wr_cnt, 4);
  endtask

  task automatic t_call;
    run(7);
    check("R5 low push we", mem_we, 1);
    check("R5 low push addr", mem_addr, SP0);
    check("R5 low push data", mem_wdata, 8'h2C);
    run(1);
    check("R5 sp after low", dbg_sp, SP0 - 16'd1);
    check("R8 we drops", mem_we, 0);
    run(1);
    check("R5 high push addr", mem_addr, SP0 - 16'd1);
    check("R5 high push data", mem_wdata, 8'h01);
    run(3);
    check("R6 pc from Z", dbg_pc, 32'h0040);
    check("R5 final sp", dbg_sp, SP0 - 16'd2);
    check("R5 stack low", mem[SP0[9:0]], 8'h2C);
    check("R5 stack high", mem[SP0[9:0] - 10'd1], 8'h01);
    check("R6 step", dbg_step, 0);
  endtask

  task automatic t_after_call;
    run(13);
    check("R6 target executed", mem[16'h00FD], SRC);
    check("R6 pc at target", dbg_pc, 32'h0042);
    check("R8 write count", wr_cnt, 7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_store_first();
    t_store_walk();
    t_bad_op();
    t_call();
    t_after_call();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule